// File: doc/BRIEF.md
# Triggered I/Q Trace Capture Buffer

This block stores decimated per-channel I and Q results in a two-half circular buffer and hands each completed half to a reader that runs on its own clock. A strobe marks each new set of results, one I and one Q value per channel, each a signed `RW`-bit number. A keep mask picks the channels that are stored. A trigger input and a 2-bit mode input decide when capture runs: continuously, once per trigger, or continuously from the first strobe after a trigger.

After each strobe the writer walks through the channels one word per cycle. A word is either a packed pair, with I in the upper half-word and Q in the lower, each cut to its 16 most significant bits, or a full-resolution value sign-extended to 32 bits, with I and Q in separate words. When the last address of a half has been written and the reader owns no half, that half is handed over and the writer moves to the other half. The reader sees `ro_enable`, reads words by address with one cycle of latency, and releases the half with `ro_ack`. A status word gives the trigger mode, the ready flag, the ready half and the fill level of the half being written.

Top module: `iq_trace_capture`

## Requirements
- R1: After reset `ro_enable` is 0 and the fill field of `ro_status` is 0.
- R2: With `pack16`=1, each kept channel gives one word per strobe: bits [31:16] are I[RW-1:RW-16] and bits [15:0] are Q[RW-1:RW-16]. Words are stored in ascending channel order, strobes in arrival order, starting at address 0 of the half.
- R3: Channel n is stored only when `keep[n]` is 1. Channels whose keep bit is 0 take no address.
- R4: With `pack16`=0, each kept channel gives two words per strobe, I first and then Q. Each word holds the value in bits [RW-1:0], and every bit above that is a copy of the sign bit.
- R5: When the last address of a half is written and the reader owns no half, `ro_enable` rises and `ro_status[28]` shows that half. The first half handed over after reset is half 0.
- R6: `ro_ack` while `ro_enable` is 1 drops `ro_enable` on the next `ro_clk` edge and releases the half. `ro_ack` while `ro_enable` is 0 has no effect.
- R7: In mode 0 (free-run), capture runs without a trigger, and each handover moves the writer to the other half.
- R8: If a half completes while the reader still owns the other half, the writer does not swap. It restarts the same half at address 0, and the half being read stays unchanged.
- R9: In mode 1 (single-shot), strobes before a trigger are not stored. Capture starts on the first strobe after the trigger and stops once one half has been handed over. It resumes only after a new trigger.
- R10: In mode 2 (sync-start), strobes before a trigger are not stored. From the first strobe after the trigger, capture runs as in free-run.
- R11: In mode 3, nothing is stored and triggers have no effect.
- R12: `ro_status` layout: [31:30] trigger mode, [29] `ro_enable`, [28] ready half, [15:0] number of words written in the half now being filled. All other bits are 0.
- R13: `ro_data` is the word at `ro_addr` in the ready half, one `ro_clk` edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous reset, active high, write side |
| samp_stb | input | 1 | Marks a new set of channel results |
| samp_i | input | NCH*RW | Signed I values, channel n at bits [n*RW +: RW] |
| samp_q | input | NCH*RW | Signed Q values, same layout |
| keep | input | NCH | Bit n enables storage of channel n |
| pack16 | input | 1 | 1: packed I/Q words; 0: full-resolution words |
| trig | input | 1 | Trigger pulse |
| trig_mode | input | 2 | 0 free-run, 1 single-shot, 2 sync-start, 3 idle |
| ro_clk | input | 1 | Readout clock |
| ro_rst | input | 1 | Synchronous reset, active high, readout side |
| ro_addr | input | HALF_AW | Word address inside the ready half |
| ro_ack | input | 1 | Releases the ready half |
| ro_enable | output | 1 | A completed half is ready to read |
| ro_data | output | 32 | Read word |
| ro_status | output | 32 | Mode, ready flag, ready half, fill level |

## Verification
A wrong half-select or a skipped address shows up in `ro_data` on the first read of a half: words come out of order, or words from earlier strobes come back. A lost handshake state shows at `ro_enable`. It either never rises after a half completes, or it stays high after an acknowledge, so the first `ro_clk` edge after `ro_ack` exposes it. Errors in the trigger state appear as a fill level other than zero in `ro_status` a few readout cycles after strobes that should have been dropped, or as a ready half holding data from before the trigger.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
   typedef enum logic [1:0] {
      TM_FREE   = 2'd0,
      TM_SINGLE = 2'd1,
      TM_SYNC   = 2'd2,
      TM_IDLE   = 2'd3
   } trig_mode_e;
endpackage

// File: rtl/iqt_sync.sv
module iqt_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q, sync_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= d;
         sync_q <= meta_q;
      end
   end

   assign q = sync_q;
endmodule

// File: rtl/iqt_store.sv
module iqt_store #(
   parameter int HALF_AW = 7
) (
   input  logic             wclk,
   input  logic             we,
   input  logic [HALF_AW:0] wa,
   input  logic [31:0]      wd,
   input  logic             rclk,
   input  logic [HALF_AW:0] ra,
   output logic [31:0]      rd
);
   localparam int DEPTH = 2 ** (HALF_AW + 1);

   logic [31:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[wa] <= wd;
   end

   always_ff @(posedge rclk) begin
      rd <= mem[ra];
   end
endmodule

// File: rtl/iqt_writer.sv
module iqt_writer
   import iqt_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int RW      = 20,
   parameter int HALF_AW = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              samp_stb,
   input  logic [NCH*RW-1:0] samp_i,
   input  logic [NCH*RW-1:0] samp_q,
   input  logic [NCH-1:0]    keep,
   input  logic              pack16,
   input  logic              trig,
   input  logic [1:0]        trig_mode,
   input  logic              ack_s,
   output logic              we,
   output logic [HALF_AW:0]  wa,
   output logic [31:0]       wd,
   output logic              full_o,
   output logic              rd_half_o,
   output logic [HALF_AW-1:0] fill_gray_o
);
   localparam int NSLOT = 2 * NCH;
   localparam int SW    = $clog2(NSLOT);
   localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [HALF_AW-1:0] LAST_A = '1;

   trig_mode_e mode;
   logic busy_q, armed_q, cap_on_q, full_q, wsel_q, rd_half_q, pack_q;
   logic [SW-1:0]      slot_q, last_slot;
   logic [NCH-1:0]     keep_q;
   logic [NCH*RW-1:0]  i_q, q_q;
   logic [HALF_AW-1:0] waddr_q, fill_g_q;
   logic [CW-1:0]      ch;
   logic               comp, start_ok, done_half, handover;
   logic [RW-1:0]      iv, qv, v;

   assign mode      = trig_mode_e'(trig_mode);
   assign last_slot = pack_q ? SW'(NCH - 1) : SW'(NSLOT - 1);
   assign ch        = pack_q ? CW'(slot_q) : CW'(slot_q >> 1);
   assign comp      = pack_q ? 1'b0 : slot_q[0];
   assign iv        = i_q[ch*RW +: RW];
   assign qv        = q_q[ch*RW +: RW];
   assign v         = comp ? qv : iv;

   assign we        = busy_q & keep_q[ch];
   assign wa        = {wsel_q, waddr_q};
   assign wd        = pack_q ? {iv[RW-1 -: 16], qv[RW-1 -: 16]}
                             : {{(32-RW){v[RW-1]}}, v};

   assign start_ok  = (mode != TM_IDLE) &&
                      (mode == TM_FREE || cap_on_q || armed_q);
   assign done_half = we && (waddr_q == LAST_A);
   assign handover  = done_half && !full_q && !ack_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q    <= 1'b0;
         armed_q   <= 1'b0;
         cap_on_q  <= 1'b0;
         full_q    <= 1'b0;
         wsel_q    <= 1'b0;
         rd_half_q <= 1'b0;
         pack_q    <= 1'b0;
         slot_q    <= '0;
         keep_q    <= '0;
         i_q       <= '0;
         q_q       <= '0;
         waddr_q   <= '0;
         fill_g_q  <= '0;
      end else begin
         fill_g_q <= waddr_q ^ (waddr_q >> 1);
         if (ack_s) full_q <= 1'b0;
         if (trig && !cap_on_q && !busy_q &&
             (mode == TM_SINGLE || mode == TM_SYNC))
            armed_q <= 1'b1;
         if (!busy_q) begin
            if (samp_stb && start_ok) begin
               busy_q <= 1'b1;
               slot_q <= '0;
               i_q    <= samp_i;
               q_q    <= samp_q;
               keep_q <= keep;
               pack_q <= pack16;
               if (mode != TM_FREE) begin
                  cap_on_q <= 1'b1;
                  armed_q  <= 1'b0;
               end
            end
         end else begin
            if (slot_q == last_slot) busy_q <= 1'b0;
            else                     slot_q <= slot_q + 1'b1;
            if (we) waddr_q <= waddr_q + 1'b1;
            if (handover) begin
               full_q    <= 1'b1;
               rd_half_q <= wsel_q;
               wsel_q    <= ~wsel_q;
               if (mode == TM_SINGLE) begin
                  cap_on_q <= 1'b0;
                  busy_q   <= 1'b0;
               end
            end
         end
      end
   end

   assign full_o      = full_q;
   assign rd_half_o   = rd_half_q;
   assign fill_gray_o = fill_g_q;

   a_r5_full_after_last: assert property (@(posedge clk) disable iff (rst)
      $rose(full_q) |-> $past(done_half));
   a_r8_ready_half_held: assert property (@(posedge clk) disable iff (rst)
      (full_q && $past(full_q)) |-> $stable(rd_half_q));
   a_r6_ack_releases: assert property (@(posedge clk) disable iff (rst)
      (ack_s && full_q) |=> !full_q);
   a_r9_single_stops: assert property (@(posedge clk) disable iff (rst)
      (handover && mode == TM_SINGLE) |=> (!busy_q && !cap_on_q));
   a_r11_idle_no_start: assert property (@(posedge clk) disable iff (rst)
      (!busy_q && mode == TM_IDLE) |=> !busy_q);
endmodule

// File: rtl/iqt_reader.sv
module iqt_reader (
   input  logic ro_clk,
   input  logic ro_rst,
   input  logic full_s,
   input  logic ro_ack,
   output logic ro_enable,
   output logic acked
);
   logic acked_q;

   always_ff @(posedge ro_clk) begin
      if (ro_rst)                      acked_q <= 1'b0;
      else if (!full_s)                acked_q <= 1'b0;
      else if (ro_ack && ro_enable)    acked_q <= 1'b1;
   end

   assign ro_enable = full_s & ~acked_q;
   assign acked     = acked_q;

   a_r6_enable_drops: assert property (@(posedge ro_clk) disable iff (ro_rst)
      (ro_ack && ro_enable) |=> !ro_enable);
endmodule

// File: rtl/iq_trace_capture.sv
module iq_trace_capture #(
   parameter int NCH     = 4,
   parameter int RW      = 20,
   parameter int HALF_AW = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              samp_stb,
   input  logic [NCH*RW-1:0] samp_i,
   input  logic [NCH*RW-1:0] samp_q,
   input  logic [NCH-1:0]    keep,
   input  logic              pack16,
   input  logic              trig,
   input  logic [1:0]        trig_mode,
   input  logic              ro_clk,
   input  logic              ro_rst,
   input  logic [HALF_AW-1:0] ro_addr,
   input  logic              ro_ack,
   output logic              ro_enable,
   output logic [31:0]       ro_data,
   output logic [31:0]       ro_status
);
   localparam int SYW = 4 + HALF_AW;

   if (RW < 16 || RW > 31) begin : g_bad_rw
      $error("RW must lie in 16..31");
   end
   if (HALF_AW < 1 || HALF_AW > 16) begin : g_bad_aw
      $error("HALF_AW must lie in 1..16");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end

   logic              we, full, rd_half, acked, ack_s;
   logic [HALF_AW:0]  wa;
   logic [31:0]       wd;
   logic [HALF_AW-1:0] fill_g, fill_gs, fill_b;
   logic [1:0]        mode_s;
   logic              full_s, half_s;

   iqt_writer #(.NCH(NCH), .RW(RW), .HALF_AW(HALF_AW)) u_writer (
      .clk(clk), .rst(rst), .samp_stb(samp_stb), .samp_i(samp_i),
      .samp_q(samp_q), .keep(keep), .pack16(pack16), .trig(trig),
      .trig_mode(trig_mode), .ack_s(ack_s), .we(we), .wa(wa), .wd(wd),
      .full_o(full), .rd_half_o(rd_half), .fill_gray_o(fill_g)
   );

   iqt_sync #(.W(SYW)) u_to_ro (
      .clk(ro_clk), .rst(ro_rst),
      .d({trig_mode, full, rd_half, fill_g}),
      .q({mode_s, full_s, half_s, fill_gs})
   );

   iqt_sync #(.W(1)) u_to_wr (
      .clk(clk), .rst(rst), .d(acked), .q(ack_s)
   );

   iqt_reader u_reader (
      .ro_clk(ro_clk), .ro_rst(ro_rst), .full_s(full_s), .ro_ack(ro_ack),
      .ro_enable(ro_enable), .acked(acked)
   );

   iqt_store #(.HALF_AW(HALF_AW)) u_store (
      .wclk(clk), .we(we), .wa(wa), .wd(wd),
      .rclk(ro_clk), .ra({half_s, ro_addr}), .rd(ro_data)
   );

   always_comb begin
      fill_b[HALF_AW-1] = fill_gs[HALF_AW-1];
      for (int k = HALF_AW - 2; k >= 0; k--)
         fill_b[k] = fill_b[k+1] ^ fill_gs[k];
   end

   assign ro_status = {mode_s, ro_enable, half_s, 12'd0, 16'(fill_b)};
endmodule

// File: tb/tb_iq_trace_capture.sv
module tb_iq_trace_capture;
   localparam int NCH = 4;
   localparam int RW = 20;
   localparam int HAW = 4;
   localparam int HALF = 2 ** HAW;

   logic clk = 0, ro_clk = 0;
   logic rst = 1, ro_rst = 1;
   logic samp_stb = 0, pack16 = 1, trig = 0, ro_ack = 0;
   logic [NCH*RW-1:0] samp_i = '0, samp_q = '0;
   logic [NCH-1:0] keep = '1;
   logic [1:0] trig_mode = 0;
   logic [HAW-1:0] ro_addr = '0;
   logic ro_enable;
   logic [31:0] ro_data, ro_status;

   int checks = 0, failures = 0, seq = 0;
   logic [31:0] pend[$];

   always #2.5 clk = ~clk;
   always #3.5 ro_clk = ~ro_clk;

   iq_trace_capture #(.NCH(NCH), .RW(RW), .HALF_AW(HAW)) dut (
      .clk(clk), .rst(rst), .samp_stb(samp_stb), .samp_i(samp_i),
      .samp_q(samp_q), .keep(keep), .pack16(pack16), .trig(trig),
      .trig_mode(trig_mode), .ro_clk(ro_clk), .ro_rst(ro_rst),
      .ro_addr(ro_addr), .ro_ack(ro_ack), .ro_enable(ro_enable),
      .ro_data(ro_data), .ro_status(ro_status)
   );

   function automatic logic [19:0] ival(int s, int c);
      return 20'(s * 54321 + c * 77777 + 4242);
   endfunction
   function automatic logic [19:0] qval(int s, int c);
      return 20'((s * 98765) ^ (c * 31337 + 999));
   endfunction
   function automatic logic [31:0] sext(logic [19:0] x);
      return {{12{x[19]}}, x};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1; ro_rst = 1; samp_stb = 0; trig = 0; ro_ack = 0;
      pend.delete();
      repeat (4) @(negedge ro_clk);
      rst = 0; ro_rst = 0;
      repeat (4) @(negedge ro_clk);
   endtask

   task automatic strobe(input bit rec);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         samp_i[c*RW +: RW] = ival(seq, c);
         samp_q[c*RW +: RW] = qval(seq, c);
         if (rec && keep[c]) begin
            if (pack16) pend.push_back({ival(seq, c)[19:4], qval(seq, c)[19:4]});
            else begin
               pend.push_back(sext(ival(seq, c)));
               pend.push_back(sext(qval(seq, c)));
            end
         end
      end
      samp_stb = 1;
      @(negedge clk);
      samp_stb = 0;
      seq++;
      repeat (10) @(negedge clk);
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic settle();
      repeat (8) @(negedge ro_clk);
   endtask

   task automatic expect_enable(input bit exp, input string req);
      settle();
      check(ro_enable == exp, req, 32'(ro_enable), 32'(exp));
   endtask

   task automatic expect_fill(input int exp, input string req);
      settle();
      check(ro_status[15:0] == 16'(exp), req, 32'(ro_status[15:0]), 32'(exp));
   endtask

   task automatic read_half(input bit half, input string req);
      check(ro_status[28] == half, {req, " half"}, 32'(ro_status[28]), 32'(half));
      for (int a = 0; a < HALF; a++) begin
         logic [31:0] e;
         e = pend.pop_front();
         @(negedge ro_clk); ro_addr = HAW'(a);
         @(negedge ro_clk);
         check(ro_data == e, req, ro_data, e);
      end
   endtask

   task automatic do_ack();
      @(negedge ro_clk); ro_ack = 1;
      @(negedge ro_clk); ro_ack = 0;
      check(ro_enable == 0, "R6 ack drops enable", 32'(ro_enable), 0);
      settle(); settle();
   endtask

   task automatic t_reset_packed();
      trig_mode = 0; pack16 = 1; keep = '1;
      do_reset();
      check(ro_enable == 0, "R1 enable", 32'(ro_enable), 0);
      check(ro_status == 32'd0, "R1/R12 status", ro_status, 0);
      @(negedge ro_clk); ro_ack = 1;
      @(negedge ro_clk); ro_ack = 0;
      for (int s = 0; s < 4; s++) strobe(1);
      expect_enable(1, "R5/R6 ready after idle ack");
      check(ro_status[29] == 1, "R12 ready bit", ro_status, 32'h2000_0000);
      read_half(0, "R2/R13 packed");
      do_ack();
      check(ro_status[29] == 0, "R12 ready bit clear", ro_status, 0);
   endtask

   task automatic t_keep();
      trig_mode = 0; pack16 = 1; keep = 4'b1010;
      do_reset();
      for (int s = 0; s < 7; s++) strobe(1);
      expect_enable(0, "R3 not yet full");
      expect_fill(14, "R3/R12 fill");
      strobe(1);
      expect_enable(1, "R3 ready");
      read_half(0, "R3 masked channels");
   endtask

   task automatic t_wide();
      trig_mode = 0; pack16 = 0; keep = 4'b0001;
      do_reset();
      for (int s = 0; s < 8; s++) strobe(1);
      expect_enable(1, "R4 ready");
      read_half(0, "R4 wide sign-extended");
   endtask

   task automatic t_skip_swap();
      trig_mode = 0; pack16 = 1; keep = '1;
      do_reset();
      for (int s = 0; s < 4; s++) strobe(1);
      for (int s = 0; s < 4; s++) strobe(0);
      strobe(1); strobe(1);
      expect_fill(8, "R8 restart same half");
      check(ro_enable == 1, "R8 ready kept", 32'(ro_enable), 1);
      read_half(0, "R8 read half unchanged");
      do_ack();
      strobe(1); strobe(1);
      expect_enable(1, "R7 second half ready");
      read_half(1, "R7/R8 other half");
   endtask

   task automatic t_single();
      trig_mode = 1; pack16 = 1; keep = '1;
      do_reset();
      check(ro_status[31:30] == 2'd1, "R12 mode field", ro_status, 32'h4000_0000);
      strobe(0); strobe(0);
      expect_fill(0, "R9 before trigger");
      pulse_trig();
      for (int s = 0; s < 4; s++) strobe(1);
      expect_enable(1, "R9 ready");
      read_half(0, "R9 post-trigger data");
      do_ack();
      strobe(0); strobe(0);
      expect_fill(0, "R9 stopped");
      check(ro_enable == 0, "R9 no new ready", 32'(ro_enable), 0);
   endtask

   task automatic t_sync();
      trig_mode = 2; pack16 = 1; keep = '1;
      do_reset();
      strobe(0); strobe(0);
      expect_fill(0, "R10 before trigger");
      pulse_trig();
      for (int s = 0; s < 4; s++) strobe(1);
      expect_enable(1, "R10 ready");
      read_half(0, "R10 first half");
      do_ack();
      for (int s = 0; s < 4; s++) strobe(1);
      expect_enable(1, "R10 continues");
      read_half(1, "R10 second half");
   endtask

   task automatic t_idle();
      trig_mode = 3; pack16 = 1; keep = '1;
      do_reset();
      pulse_trig();
      for (int s = 0; s < 4; s++) strobe(0);
      expect_fill(0, "R11 idle fill");
      check(ro_enable == 0, "R11 idle enable", 32'(ro_enable), 0);
      check(ro_status[31:30] == 2'd3, "R12 mode 3", ro_status, 32'hC000_0000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset_packed();
      t_keep();
      t_wide();
      t_skip_swap();
      t_single();
      t_sync();
      t_idle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule